// File: doc/BRIEF.md
# Three-Channel Dead-Time Inserter

This block sits between a PWM compare stage and the gate drivers of a three-phase bridge. Each channel receives one compare state bit. From it the block derives a high-side drive and a low-side drive that are complements of each other. When the compare state of a channel changes, the block holds both drives of that channel low for a programmable number of clock cycles. This wait stops the two switches of one leg from conducting together.

All channels share one delay value. Each channel has its own countdown counter, its own enable and its own busy flag, so the three legs switch independently of each other. A single synchronous strobe empties all counters in the same cycle. The compare state inputs are taken as already synchronous to the clock. A compare state of 1 means the high side is active, and 0 means the low side is active.

Top module: `deadband_trio`

## Requirements
- R1: When a channel is enabled and its compare state changes with a shared delay D greater than 0, both drives of that channel are 0 for exactly D cycles. The first of these is the cycle in which the new compare state is presented.
- R2: The busy flag of a channel is 1 in exactly the cycles in which R1 or R7 holds that channel's drives low, and it is 0 otherwise.
- R3: The high-side and low-side drives of a channel are never 1 at the same time. The passive state is both drives at 0.
- R4: While a channel is not busy, its high-side drive equals its compare state bit and its low-side drive equals the inverse of that bit.
- R5: With a delay of 0, a compare state change appears on the drives in the same cycle, and the busy flag stays 0.
- R6: While a channel's enable is 0, that channel's busy flag is 0 and its drives follow R4 with no delay. Any count in progress is discarded.
- R7: A compare state change during a count in progress restarts the count. The drives stay 0 for D cycles counted from the cycle of the new change.
- R8: While the clear strobe is 1, no count is started. From the cycle after the strobe, every channel is not busy.
- R9: A change on one channel has no effect on the drives or busy flags of the other channels.
- R10: After reset, the counters are 0 and the stored previous compare state is 0. With all enables at 0, the busy flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_state | input | NCH | Compare state per channel (1 = high side active) |
| ch_en | input | NCH | Dead-time enable per channel |
| dly_val | input | DLY_W | Shared dead-time length in cycles |
| dt_clr | input | 1 | Synchronous strobe that empties all counters |
| hs_out | output | NCH | High-side drive per channel |
| ls_out | output | NCH | Low-side drive per channel |
| dt_busy | output | NCH | Per-channel flag, high while its dead time runs |

## Verification
The assertions take the compare state, enable, delay and strobe inputs as synchronous. They also take these inputs as stable around the rising edge, because the drives are computed combinationally from the present compare state. The load check compares the counter with the delay as it was at the load edge, so it still holds if the delay changes during a count. The stimulus changes every input only on the falling clock edge. It includes delay changes, enable drops during a count, and strobes that coincide with a change, all applied at that edge.

// File: rtl/deadband_pkg.sv
package deadband_pkg;

   // operation chosen for a channel counter in the current cycle
   typedef enum logic [1:0] {
      CNT_IDLE = 2'd0,
      CNT_LOAD = 2'd1,
      CNT_DEC  = 2'd2,
      CNT_CLR  = 2'd3
   } cnt_op_e;

   localparam int unsigned MAX_CH = 16;

endpackage

// File: rtl/db_edge.sv
module db_edge #(
   parameter int unsigned NCH = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] cmp_in,
   output logic [NCH-1:0] chg
);

   logic [NCH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cmp_in;
   end

   assign chg = cmp_in ^ prev_q;

   // a change seen in one cycle means the stored copy matches next cycle
   AST_CHG_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(cmp_in) && !$isunknown(cmp_in)) |-> chg == '0) else $error("stored compare state lost"); // R10

endmodule

// File: rtl/db_counter.sv
module db_counter
   import deadband_pkg::*;
#(
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             chg,
   input  logic             clr,
   input  logic [DLY_W-1:0] dly,
   output logic             busy
);

   logic [DLY_W-1:0] cnt_q;
   cnt_op_e          op;
   logic             start_wait;

   always_comb begin
      if (!en || clr)      op = CNT_CLR;
      else if (chg)        op = CNT_LOAD;
      else if (cnt_q != '0) op = CNT_DEC;
      else                 op = CNT_IDLE;
   end

   // the change cycle is the first passive cycle, so D-1 remain after it
   assign start_wait = (op == CNT_LOAD) && (dly != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else begin
         case (op)
            CNT_CLR:  cnt_q <= '0;
            CNT_LOAD: cnt_q <= (dly == '0) ? '0 : dly - DLY_W'(1);
            CNT_DEC:  cnt_q <= cnt_q - DLY_W'(1);
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign busy = en && ((cnt_q != '0) || start_wait);

   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0)) else $error("strobe left a count"); // R8

   AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && chg && !clr && dly != '0) |=> (cnt_q == $past(dly) - DLY_W'(1))) else $error("bad load"); // R1

   AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !chg && !clr && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - DLY_W'(1))) else $error("bad step"); // R2

   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !busy) else $error("disabled channel busy"); // R6

   AST_ZERO_DLY: assert property (@(posedge clk) disable iff (!rst_n)
      (dly == '0 && cnt_q == '0) |-> !busy) else $error("zero delay waited"); // R5

endmodule

// File: rtl/db_gate.sv
module db_gate (
   input  logic cmp,
   input  logic hold,
   output logic hs,
   output logic ls
);

   assign hs = cmp  && !hold;
   assign ls = !cmp && !hold;

endmodule

// File: rtl/deadband_trio.sv
module deadband_trio
   import deadband_pkg::*;
#(
   parameter int unsigned NCH   = 3,
   parameter int unsigned DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   cmp_state,
   input  logic [NCH-1:0]   ch_en,
   input  logic [DLY_W-1:0] dly_val,
   input  logic             dt_clr,
   output logic [NCH-1:0]   hs_out,
   output logic [NCH-1:0]   ls_out,
   output logic [NCH-1:0]   dt_busy
);

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("NCH out of range");
   end
   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dlyw
      $error("DLY_W out of range");
   end

   logic [NCH-1:0] chg;

   db_edge #(.NCH(NCH)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmp_in (cmp_state),
      .chg    (chg)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      db_counter #(.DLY_W(DLY_W)) u_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (ch_en[i]),
         .chg   (chg[i]),
         .clr   (dt_clr),
         .dly   (dly_val),
         .busy  (dt_busy[i])
      );

      db_gate u_gate (
         .cmp  (cmp_state[i]),
         .hold (dt_busy[i]),
         .hs   (hs_out[i]),
         .ls   (ls_out[i])
      );

      AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
         !(hs_out[i] && ls_out[i])) else $error("both drives high"); // R3

      AST_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
         dt_busy[i] |-> (!hs_out[i] && !ls_out[i])) else $error("drive during dead time"); // R1

      AST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
         !dt_busy[i] |-> (hs_out[i] == cmp_state[i] && ls_out[i] == !cmp_state[i])) else $error("drive not following"); // R4

      AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         (dt_clr && !$past(dt_clr)) |=> (!dt_busy[i] || $past(chg[i]) == 1'b0)) else $error("busy after strobe"); // R8
   end

endmodule

// File: tb/deadband_trio_test.sv
module deadband_trio_test;

   localparam int NCH   = 3;
   localparam int DLY_W = 4;

   typedef struct {
      logic [NCH-1:0] hs;
      logic [NCH-1:0] ls;
      logic [NCH-1:0] busy;
      string          tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NCH-1:0]   cmp_state = '0;
   logic [NCH-1:0]   ch_en = '0;
   logic [DLY_W-1:0] dly_val = '0;
   logic             dt_clr = 1'b0;
   logic [NCH-1:0]   hs_out, ls_out, dt_busy;

   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   logic [DLY_W-1:0] m_cnt [NCH];
   logic [NCH-1:0]   m_prev = '0;

   always #2 clk = ~clk;

   deadband_trio #(.NCH(NCH), .DLY_W(DLY_W)) uut (
      .clk(clk), .rst_n(rst_n), .cmp_state(cmp_state), .ch_en(ch_en),
      .dly_val(dly_val), .dt_clr(dt_clr),
      .hs_out(hs_out), .ls_out(ls_out), .dt_busy(dt_busy)
   );

   // driver: apply one cycle of stimulus and push the expected outputs
   task automatic step(input logic [NCH-1:0] c, input logic [NCH-1:0] e,
                       input logic [DLY_W-1:0] d, input logic k, input string tag);
      exp_t x;
      @(negedge clk);
      cmp_state = c; ch_en = e; dly_val = d; dt_clr = k;
      for (int i = 0; i < NCH; i++) begin
         logic ld, b;
         ld = e[i] && (c[i] != m_prev[i]) && !k;
         b  = e[i] && ((m_cnt[i] != '0) || (ld && d != '0));
         x.busy[i] = b;
         x.hs[i]   = c[i] && !b;
         x.ls[i]   = !c[i] && !b;
      end
      x.tag = tag;
      sb_q.push_back(x);
      @(posedge clk);
      for (int i = 0; i < NCH; i++) begin
         logic ld;
         ld = e[i] && (c[i] != m_prev[i]) && !k;
         if (!e[i] || k)      m_cnt[i] = '0;
         else if (ld)         m_cnt[i] = (d == '0) ? '0 : d - DLY_W'(1);
         else if (m_cnt[i] != '0) m_cnt[i] = m_cnt[i] - DLY_W'(1);
      end
      m_prev = c;
   endtask

   // monitor: compare well after the falling edge, before the rising edge
   always @(negedge clk) begin
      #1;
      while (sb_q.size() > 0) begin
         exp_t x;
         x = sb_q.pop_front();
         checks++;
         if (hs_out !== x.hs || ls_out !== x.ls || dt_busy !== x.busy) begin
            errors++;
            $display("FAIL %s hs=%b ls=%b busy=%b expected hs=%b ls=%b busy=%b",
                     x.tag, hs_out, ls_out, dt_busy, x.hs, x.ls, x.busy);
         end
      end
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCH; i++) m_cnt[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state with enables off
      checks++;
      if (dt_busy !== 3'b000 || hs_out !== 3'b000 || ls_out !== 3'b111) begin
         errors++;
         $display("FAIL R10 hs=%b ls=%b busy=%b expected hs=000 ls=111 busy=000",
                  hs_out, ls_out, dt_busy);
      end
      @(negedge clk);
      rst_n = 1'b1;
      step(3'b000, 3'b111, 4'd3, 1'b0, "R10");
      // R1 R2: channel 0 rises with D=3
      step(3'b001, 3'b111, 4'd3, 1'b0, "R1");
      step(3'b001, 3'b111, 4'd3, 1'b0, "R2");
      step(3'b001, 3'b111, 4'd3, 1'b0, "R2");
      step(3'b001, 3'b111, 4'd3, 1'b0, "R4");
      // R1 falling edge, R9 channel 2 independent
      step(3'b100, 3'b111, 4'd3, 1'b0, "R9");
      step(3'b100, 3'b111, 4'd3, 1'b0, "R3");
      step(3'b100, 3'b111, 4'd3, 1'b0, "R2");
      step(3'b100, 3'b111, 4'd3, 1'b0, "R4");
      // R7: retrigger channel 1 mid-count with D=4
      step(3'b110, 3'b111, 4'd4, 1'b0, "R7");
      step(3'b110, 3'b111, 4'd4, 1'b0, "R7");
      step(3'b100, 3'b111, 4'd4, 1'b0, "R7");
      for (int k = 0; k < 5; k++) step(3'b100, 3'b111, 4'd4, 1'b0, "R7");
      // R5: zero delay switches in the same cycle
      step(3'b011, 3'b111, 4'd0, 1'b0, "R5");
      step(3'b000, 3'b111, 4'd0, 1'b0, "R5");
      step(3'b000, 3'b111, 4'd0, 1'b0, "R5");
      // R6: channel 1 disabled, channel 0 drops enable mid-count
      step(3'b010, 3'b101, 4'd5, 1'b0, "R6");
      step(3'b011, 3'b111, 4'd5, 1'b0, "R6");
      step(3'b011, 3'b110, 4'd5, 1'b0, "R6");
      step(3'b011, 3'b111, 4'd5, 1'b0, "R6");
      // R8: strobe during counts, and coinciding with a change
      step(3'b100, 3'b111, 4'd6, 1'b0, "R8");
      step(3'b100, 3'b111, 4'd6, 1'b0, "R8");
      step(3'b101, 3'b111, 4'd6, 1'b1, "R8");
      step(3'b101, 3'b111, 4'd6, 1'b0, "R8");
      step(3'b101, 3'b111, 4'd6, 1'b0, "R8");
      // maximum delay, all channels together
      step(3'b010, 3'b111, 4'd15, 1'b0, "R1");
      for (int k = 0; k < 16; k++) step(3'b010, 3'b111, 4'd15, 1'b0, "R2");
      step(3'b010, 3'b111, 4'd15, 1'b0, "R4");
      @(negedge clk);
      #2;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule